// File: doc/BRIEF.md
# Single-Byte Command Target for a Two-Wire Serial Bus

This block sits on a two-wire serial bus (I2C) as a write-only target. A controller opens a frame with a START, sends the target's 7-bit address with the write direction, and then sends exactly one command byte. The target acknowledges both bytes by pulling the data line low. When the acknowledge clock of the command byte ends, it applies the command to two pieces of state: a 6-bit volume setting and a one-bit output modulation selector.

The command byte is an opcode, not a raw value. Its upper two bits choose the operation and its lower six bits carry an argument. Opcode 00 loads the argument as the new volume. Opcode 01 picks the modulation scheme. Opcode 11 steps the volume up or down by one. Opcode 10 is reserved.

Both bus lines are brought into the clock domain through a synchronizer chain. Bus events (START, STOP, clock edges) are found by comparing consecutive synchronized samples. The block is used with an external pull-up: it only ever pulls the data line low, through `sda_pull`.

Top module: `cmd_byte_target`

## Requirements
- R1: While reset is asserted and immediately after it, `volume` is 0, `pwm_mode` is 0 (filterless) and `sda_pull` is 0.
- R2: A frame whose first byte is `{own_addr, 1'b0}` (address in bits 7:1, write direction 0 in bit 0) is acknowledged: `sda_pull` is high during the ninth clock high time. The following command byte is acknowledged in the same way.
- R3: A first byte whose bits 7:1 differ from `own_addr`, or whose bit 0 is 1, gets no acknowledge. Nothing else on the bus is acknowledged until the next START, and no state changes.
- R4: Command byte bits 7:6 = 00 loads bits 5:0 into `volume`.
- R5: Bits 7:6 = 01 with argument 0 sets `pwm_mode` to 0, and with argument 1 sets it to 1. Any other argument under 01 leaves `volume` and `pwm_mode` unchanged.
- R6: Byte 0xC4 (opcode 11, argument 4) raises `volume` by one and stops at 63. Byte 0xC5 (argument 5) lowers it by one and stops at 0. Other arguments under 11 change nothing.
- R7: Bytes with bits 7:6 = 10 are acknowledged but change neither `volume` nor `pwm_mode`.
- R8: A START or STOP that arrives before the command byte's acknowledge clock has ended aborts the frame, and no command is applied.
- R9: `sda_pull` changes only while the synchronized clock line is low. After each acknowledge clock it is released, so it is 0 once a frame has ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_addr | input | 7 | Bus address this target answers to |
| scl_in | input | 1 | Bus clock line as sensed |
| sda_in | input | 1 | Bus data line as sensed |
| sda_pull | output | 1 | High to drive the data line low (open-drain enable) |
| volume | output | 6 | Current volume setting |
| pwm_mode | output | 1 | Modulation scheme: 0 filterless, 1 classic PWM |

## Verification
The bound checker watches several properties on every cycle. It checks that the data-line pull moves only while the synchronized clock is low, and that the pull stays off in the ignoring state. It checks that volume and mode move only in the cycle after an applied command of the right opcode, that up and down steps respect their bounds, and that reserved opcodes leave both outputs unchanged. Some behaviour is visible only from whole frames, so the directed scenarios cover it: the acknowledge seen by a controller, address and direction mismatches, absolute loads, the ignored arguments, and frames cut short by a START or a STOP in mid-byte.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

   localparam int BYTE_W = 8;
   localparam int OP_W   = 2;
   localparam int ARG_W  = 6;

   typedef enum logic [OP_W-1:0] {
      OP_LOAD = 2'b00,
      OP_MODE = 2'b01,
      OP_RSVD = 2'b10,
      OP_STEP = 2'b11
   } opcode_e;

   localparam logic [ARG_W-1:0] ARG_FILTERLESS = 6'd0;
   localparam logic [ARG_W-1:0] ARG_PWM        = 6'd1;
   localparam logic [ARG_W-1:0] ARG_UP         = 6'd4;
   localparam logic [ARG_W-1:0] ARG_DOWN       = 6'd5;

   typedef enum logic [2:0] {
      FS_IDLE,
      FS_ADDR,
      FS_ADDR_ACK,
      FS_DATA,
      FS_DATA_ACK,
      FS_IGNORE
   } fstate_e;

endpackage

// File: rtl/cbt_sync.sv
module cbt_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("cbt_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/cbt_bus_watch.sv
module cbt_bus_watch (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic start_det,
   output logic stop_det,
   output logic scl_rise,
   output logic scl_fall
);

   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   // Data edges while the clock stays high mark frame boundaries.
   assign start_det = scl_p & scl_s &  sda_p & ~sda_s;
   assign stop_det  = scl_p & scl_s & ~sda_p &  sda_s;
   assign scl_rise  = ~scl_p &  scl_s;
   assign scl_fall  =  scl_p & ~scl_s;

endmodule

// File: rtl/cbt_frame_fsm.sv
module cbt_frame_fsm
   import cbt_pkg::*;
#(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              sda_s,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              scl_rise,
   input  logic              scl_fall,
   output logic              sda_pull,
   output logic              cmd_valid,
   output logic [BYTE_W-1:0] cmd_byte,
   output logic              ignoring
);

   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

   fstate_e           state;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] shreg;
   logic              addr_hit;

   assign addr_hit = (shreg[BYTE_W-1:1] == own_addr) && !shreg[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= FS_IDLE;
         bit_cnt   <= '0;
         shreg     <= '0;
         sda_pull  <= 1'b0;
         cmd_valid <= 1'b0;
      end else begin
         cmd_valid <= 1'b0;
         if (start_det) begin
            state    <= FS_ADDR;
            bit_cnt  <= '0;
            sda_pull <= 1'b0;
         end else if (stop_det) begin
            state    <= FS_IDLE;
            bit_cnt  <= '0;
            sda_pull <= 1'b0;
         end else begin
            unique case (state)
               FS_ADDR, FS_DATA: begin
                  if (scl_rise && bit_cnt != FULL) begin
                     shreg   <= {shreg[BYTE_W-2:0], sda_s};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (scl_fall && bit_cnt == FULL) begin
                     bit_cnt <= '0;
                     if (state == FS_DATA) begin
                        state    <= FS_DATA_ACK;
                        sda_pull <= 1'b1;
                     end else if (addr_hit) begin
                        state    <= FS_ADDR_ACK;
                        sda_pull <= 1'b1;
                     end else begin
                        state <= FS_IGNORE;
                     end
                  end
               end
               FS_ADDR_ACK: begin
                  if (scl_fall) begin
                     state    <= FS_DATA;
                     sda_pull <= 1'b0;
                  end
               end
               FS_DATA_ACK: begin
                  if (scl_fall) begin
                     state     <= FS_IGNORE;
                     sda_pull  <= 1'b0;
                     cmd_valid <= 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign cmd_byte = shreg;
   assign ignoring = (state == FS_IGNORE);

endmodule

// File: rtl/cbt_cmd_apply.sv
module cbt_cmd_apply
   import cbt_pkg::*;
#(
   parameter int VOL_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [BYTE_W-1:0] cmd_byte,
   output logic [VOL_W-1:0]  volume,
   output logic              pwm_mode
);

   localparam logic [VOL_W-1:0] VOL_MAX = {VOL_W{1'b1}};

   opcode_e          op;
   logic [ARG_W-1:0] arg;
   logic [VOL_W-1:0] vol_nxt;
   logic             mode_nxt;

   assign op  = opcode_e'(cmd_byte[BYTE_W-1 -: OP_W]);
   assign arg = cmd_byte[ARG_W-1:0];

   always_comb begin
      vol_nxt  = volume;
      mode_nxt = pwm_mode;
      unique case (op)
         OP_LOAD: vol_nxt = VOL_W'(arg);
         OP_MODE: begin
            if (arg == ARG_FILTERLESS) mode_nxt = 1'b0;
            else if (arg == ARG_PWM)   mode_nxt = 1'b1;
         end
         OP_STEP: begin
            if (arg == ARG_UP && volume != VOL_MAX)
               vol_nxt = volume + VOL_W'(1);
            else if (arg == ARG_DOWN && volume != '0)
               vol_nxt = volume - VOL_W'(1);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         volume   <= '0;
         pwm_mode <= 1'b0;
      end else if (cmd_valid) begin
         volume   <= vol_nxt;
         pwm_mode <= mode_nxt;
      end
   end

endmodule

// File: rtl/cmd_byte_target.sv
module cmd_byte_target
   import cbt_pkg::*;
#(
   parameter int ADDR_W      = 7,
   parameter int VOL_W       = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              sda_pull,
   output logic [VOL_W-1:0]  volume,
   output logic              pwm_mode
);

   if (ADDR_W != BYTE_W - 1) begin : g_bad_addr
      $error("cmd_byte_target: ADDR_W must be 7");
   end
   if (VOL_W != ARG_W) begin : g_bad_vol
      $error("cmd_byte_target: VOL_W must equal the argument width");
   end

   logic              scl_s, sda_s;
   logic              start_det, stop_det, scl_rise, scl_fall;
   logic              cmd_valid;
   logic [BYTE_W-1:0] cmd_byte;
   logic              ignoring;

   cbt_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s)
   );

   cbt_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s)
   );

   cbt_bus_watch u_watch (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .start_det(start_det), .stop_det(stop_det),
      .scl_rise(scl_rise), .scl_fall(scl_fall)
   );

   cbt_frame_fsm #(.ADDR_W(ADDR_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .own_addr(own_addr), .sda_s(sda_s),
      .start_det(start_det), .stop_det(stop_det),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .sda_pull(sda_pull), .cmd_valid(cmd_valid),
      .cmd_byte(cmd_byte), .ignoring(ignoring)
   );

   cbt_cmd_apply #(.VOL_W(VOL_W)) u_apply (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
      .volume(volume), .pwm_mode(pwm_mode)
   );

endmodule

// File: rtl/cbt_checker.sv
module cbt_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       sda_pull,
   input logic       scl_s,
   input logic [5:0] volume,
   input logic       pwm_mode,
   input logic       cmd_valid,
   input logic [7:0] cmd_byte,
   input logic       ignoring
);

   // R1: outputs are at their reset values while reset is held
   always @(negedge clk) begin
      if (!rst_n) begin
         a_r1_reset_values: assert (volume == 6'd0 && !pwm_mode && !sda_pull);
      end
   end

   // R9: the pull changes only while the clock line is low
   a_r9_pull_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull) |-> !scl_s);

   // R3: no acknowledge while ignoring the bus
   a_r3_silent_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      ignoring |-> !sda_pull);

   // R4: the volume moves only after an applied command
   a_r4_vol_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(volume) |-> $past(cmd_valid));

   // R5: the mode moves only after a mode command
   a_r5_mode_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pwm_mode) |-> $past(cmd_valid && cmd_byte[7:6] == 2'b01));

   // R6: step up by one below the ceiling
   a_r6_up_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_byte == 8'hC4 && volume != 6'd63) |=>
         volume == $past(volume) + 6'd1);

   // R6: ceiling holds
   a_r6_up_sat: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_byte == 8'hC4 && volume == 6'd63) |=> volume == 6'd63);

   // R6: floor holds
   a_r6_down_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_byte == 8'hC5 && volume == 6'd0) |=> volume == 6'd0);

   // R7: reserved opcodes leave the state untouched
   a_r7_reserved_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_byte[7:6] == 2'b10) |=> ($stable(volume) && $stable(pwm_mode)));

   // R8: at most one command per frame, so the apply strobe never repeats back to back
   a_r8_single_apply: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

endmodule

bind cmd_byte_target cbt_checker u_chk (.*);

// File: tb/sim_cmd_byte_target.sv
`timescale 1ns/1ps
module sim_cmd_byte_target;

   localparam int Q = 10;
   localparam logic [6:0] MY_ADDR = 7'h4B;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_pull;
   logic [5:0] volume;
   logic       pwm_mode;
   logic       sda_line;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   assign sda_line = sda_m & ~sda_pull;

   cmd_byte_target u0 (
      .clk(clk), .rst_n(rst_n), .own_addr(MY_ADDR),
      .scl_in(scl_m), .sda_in(sda_line),
      .sda_pull(sda_pull), .volume(volume), .pwm_mode(pwm_mode)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic qw(input int n);
      repeat (n * Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; scl_m = 1'b1; qw(1);
      sda_m = 1'b0; qw(1);
      scl_m = 1'b0; qw(1);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; qw(1);
      scl_m = 1'b1; qw(1);
      sda_m = 1'b1; qw(2);
   endtask

   task automatic send_bit(input logic b);
      sda_m = b;    qw(1);
      scl_m = 1'b1; qw(2);
      scl_m = 1'b0; qw(1);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      sda_m = 1'b1; qw(1);
      scl_m = 1'b1; qw(1);
      acked = !sda_line;
      qw(1);
      scl_m = 1'b0; qw(1);
   endtask

   task automatic frame(input logic [6:0] a, input logic rw, input logic [7:0] d,
                        output logic aa, output logic ad);
      bus_start();
      send_byte({a, rw}, aa);
      send_byte(d, ad);
      bus_stop();
      qw(1);
   endtask

   task automatic cmd(input logic [7:0] d, input string req);
      logic aa, ad;
      frame(MY_ADDR, 1'b0, d, aa, ad);
      chk({req, " addr ack"}, aa, 1);
      chk({req, " data ack"}, ad, 1);
   endtask

   task automatic t_reset();
      chk("R1 volume", volume, 0);
      chk("R1 mode", pwm_mode, 0);
      chk("R1 pull", sda_pull, 0);
   endtask

   task automatic t_load();
      cmd(8'h2A, "R2");
      chk("R4 load 42", volume, 42);
      cmd(8'h3F, "R2");
      chk("R4 load 63", volume, 63);
      chk("R9 released after frame", sda_pull, 0);
   endtask

   task automatic t_mode();
      cmd(8'h41, "R5");
      chk("R5 pwm", pwm_mode, 1);
      cmd(8'h47, "R5");
      chk("R5 unlisted arg mode", pwm_mode, 1);
      chk("R5 unlisted arg volume", volume, 63);
      cmd(8'h40, "R5");
      chk("R5 filterless", pwm_mode, 0);
   endtask

   task automatic t_step();
      cmd(8'h3E, "R6");
      cmd(8'hC4, "R6");
      chk("R6 up to 63", volume, 63);
      cmd(8'hC4, "R6");
      chk("R6 up saturates", volume, 63);
      cmd(8'h01, "R6");
      cmd(8'hC5, "R6");
      chk("R6 down to 0", volume, 0);
      cmd(8'hC5, "R6");
      chk("R6 down saturates", volume, 0);
      cmd(8'h10, "R6");
      cmd(8'hC7, "R6");
      chk("R6 unlisted arg", volume, 16);
   endtask

   task automatic t_reserved();
      cmd(8'h80, "R7");
      chk("R7 volume kept", volume, 16);
      chk("R7 mode kept", pwm_mode, 0);
      cmd(8'hBF, "R7");
      chk("R7 volume kept all ones", volume, 16);
   endtask

   task automatic t_mismatch();
      logic aa, ad;
      frame(7'h4A, 1'b0, 8'h05, aa, ad);
      chk("R3 wrong addr no ack", aa, 0);
      chk("R3 wrong addr data no ack", ad, 0);
      chk("R3 wrong addr volume", volume, 16);
      frame(MY_ADDR, 1'b1, 8'h41, aa, ad);
      chk("R3 read bit no ack", aa, 0);
      chk("R3 read bit mode", pwm_mode, 0);
   endtask

   task automatic t_abort();
      logic aa;
      bus_start();
      send_byte({MY_ADDR, 1'b0}, aa);
      chk("R8 addr ack", aa, 1);
      for (int i = 0; i < 4; i++) send_bit(1'b0);
      bus_start();
      bus_stop();
      chk("R8 start abort", volume, 16);
      bus_start();
      send_byte({MY_ADDR, 1'b0}, aa);
      send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
      bus_stop();
      qw(1);
      chk("R8 stop abort", volume, 16);
      chk("R9 pull off after abort", sda_pull, 0);
      cmd(8'h07, "R8");
      chk("R8 recovers", volume, 7);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_load();
      t_mode();
      t_step();
      t_reserved();
      t_mismatch();
      t_abort();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule